// File: doc/BRIEF.md
# I2C Start/Stop Condition Control Register

This block is the bus-condition part of an I2C master. It watches the SDA and SCL lines through a synchroniser and keeps a bus-busy flag. The flag is set when a start condition is seen on the lines and cleared when a stop condition is seen. Software asks for a start, a repeated start or a stop by writing one 8-bit control word. The block then produces the timed edge sequence on two open-drain output enables. A high enable pulls the line low.

A write asks for a condition only when its guard bit (bit 6) is 0. Bit 7 of that write chooses the condition: 1 asks for a start, 0 asks for a stop. A start asked for while the block is holding the bus becomes a repeated start. The busy flag is never taken from written data; it always reflects what the lines show. A read returns the busy flag, constant ones, and the levels the block is driving on SDA and SCL. All phase lengths come from a half-bit-period divider input.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: After reset, both output enables are 0. The first read returns 8'h7C: bit 7 is 0, bits 6..2 are 1, bits 1:0 are 0.
- R2: A read (rd_en_i high at a clock edge) loads rdata_o at that edge, and rdata_o holds its value while rd_en_i is low. In the read word, bit 7 is busy. Bits 6, 4 and 2 are always 1 and bits 1:0 are always 0. Bit 5 is the driven SDA level and bit 3 is the driven SCL level, where a level is 0 when the enable is 1 and 1 otherwise.
- R3: After the synchronised inputs show SDA falling while SCL is high, the busy flag is 1 within three clock cycles.
- R4: After the synchronised inputs show SDA rising while SCL is high, the busy flag is 0 within three clock cycles.
- R5: Consider a write with bit 6 = 0 and bit 7 = 1 while the block is idle. For H cycles after the write edge, sda_oe_o = 1 and scl_oe_o = 0. After that the block holds both enables at 1.
- R6: The same write while the block holds the bus runs a repeated start. For H cycles, SDA is released and SCL is held low. For H cycles both lines are released. For H cycles, SDA is low and SCL is released. The block then holds both enables at 1 again.
- R7: A write with bit 6 = 0 and bit 7 = 0 while the block holds the bus runs a stop. For H cycles, SDA is held low and SCL is released. Then both enables return to 0.
- R8: A write with bit 6 = 1 changes neither output enable nor the busy flag.
- R9: A request that arrives while a timed sequence is running is dropped. A stop request while the block is idle is dropped.
- R10: sda_oe_o and scl_oe_o never change in the same clock cycle.
- R11: H is half_div_i, except that a value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rdata_o | output | 8 | Read data, registered |
| sda_i | input | 1 | SDA line level seen at the pad |
| scl_i | input | 1 | SCL line level seen at the pad |
| half_div_i | input | DIV_W | Half bit period in clock cycles |
| sda_oe_o | output | 1 | SDA pull-down enable |
| scl_oe_o | output | 1 | SCL pull-down enable |

## Verification
The hardest case to reach is a second request that lands inside a running timed phase. The bench issues back-to-back writes a fixed number of cycles after a start. It then checks that the held state stays in place long after the phase ends. The repeated start needs the block to be holding the bus first, so random operations follow a model of whether the bus is held. An external pull-down on the modelled SDA line makes busy rise while the block drives nothing. This separates the SDA monitor bit, which shows the driven level, from the level on the line.

// File: rtl/i2c_cc_pkg.sv
package i2c_cc_pkg;
  localparam int unsigned REG_W       = 8;
  localparam int unsigned BUSY_BIT    = 7;
  localparam int unsigned GUARD_BIT   = 6;
  localparam int unsigned SDA_MON_BIT = 5;
  localparam int unsigned RSV_HI_BIT  = 4;
  localparam int unsigned SCL_MON_BIT = 3;
  localparam int unsigned RSV_LO_BIT  = 2;

  typedef enum logic [2:0] {
    GS_IDLE,
    GS_ST_SDA,   // SDA low, SCL released
    GS_HELD,     // both low, bus owned
    GS_RS_SDA,   // SDA released, SCL low
    GS_RS_SCL,   // both released
    GS_SP_SCL    // SCL released, SDA low
  } gen_state_e;

  typedef struct packed {
    logic sda;
    logic scl;
  } lines_t;
endpackage

// File: rtl/i2c_cc_bus_mon.sv
module i2c_cc_bus_mon
  import i2c_cc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic scl_i,
  output logic busy_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  lines_t sync_q [SYNC_STAGES];
  lines_t prev_q;
  logic   seen_start, seen_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= '{sda: 1'b1, scl: 1'b1};
    else         sync_q[0] <= '{sda: sda_i, scl: scl_i};
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= '{sda: 1'b1, scl: 1'b1};
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  // SCL must be high in both samples around the SDA edge
  assign seen_start = prev_q.sda & ~sync_q[LAST].sda & prev_q.scl & sync_q[LAST].scl;
  assign seen_stop  = ~prev_q.sda & sync_q[LAST].sda & prev_q.scl & sync_q[LAST].scl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '{sda: 1'b1, scl: 1'b1};
      busy_o <= 1'b0;
    end else begin
      prev_q <= sync_q[LAST];
      if (seen_start)     busy_o <= 1'b1;
      else if (seen_stop) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_cc_gen.sv
module i2c_cc_gen
  import i2c_cc_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_req_i,
  input  logic             stop_req_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sda_oe_o,
  output logic             scl_oe_o,
  output logic             idle_o
);
  gen_state_e       state_q, state_d;
  logic [DIV_W-1:0] cnt_q, half_last;
  logic             timed, phase_done;

  assign half_last  = (half_i == '0) ? '0 : half_i - DIV_W'(1);
  assign timed      = (state_q == GS_ST_SDA) || (state_q == GS_RS_SDA) ||
                      (state_q == GS_RS_SCL) || (state_q == GS_SP_SCL);
  assign phase_done = timed && (cnt_q == half_last);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GS_IDLE:   if (start_req_i) state_d = GS_ST_SDA;
      GS_HELD:   if (start_req_i)     state_d = GS_RS_SDA;
                 else if (stop_req_i) state_d = GS_SP_SCL;
      GS_ST_SDA: if (phase_done) state_d = GS_HELD;
      GS_RS_SDA: if (phase_done) state_d = GS_RS_SCL;
      GS_RS_SCL: if (phase_done) state_d = GS_ST_SDA;
      GS_SP_SCL: if (phase_done) state_d = GS_IDLE;
      default:   state_d = GS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) cnt_q <= '0;
      else if (timed)         cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign sda_oe_o = (state_q == GS_ST_SDA) || (state_q == GS_HELD) || (state_q == GS_SP_SCL);
  assign scl_oe_o = (state_q == GS_HELD) || (state_q == GS_RS_SDA);
  assign idle_o   = (state_q == GS_IDLE);
endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_cc_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             rd_en_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             sda_i,
  input  logic             scl_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             sda_oe_o,
  output logic             scl_oe_o
);
  localparam logic [REG_W-1:0] RST_VAL = REG_W'((1 << GUARD_BIT) | (1 << SDA_MON_BIT) |
                                               (1 << RSV_HI_BIT) | (1 << SCL_MON_BIT) |
                                               (1 << RSV_LO_BIT));

  logic             busy, gen_idle, req_ok, start_req, stop_req;
  logic [REG_W-1:0] rd_val;
  logic             unused_wdata;

  assign req_ok       = wr_en_i & ~wdata_i[GUARD_BIT];
  assign start_req    = req_ok &  wdata_i[BUSY_BIT];
  assign stop_req     = req_ok & ~wdata_i[BUSY_BIT];
  assign unused_wdata = ^wdata_i[SDA_MON_BIT:0];

  i2c_cc_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sda_i  (sda_i),
    .scl_i  (scl_i),
    .busy_o (busy)
  );

  i2c_cc_gen #(.DIV_W(DIV_W)) u_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_req_i (start_req),
    .stop_req_i  (stop_req),
    .half_i      (half_div_i),
    .sda_oe_o    (sda_oe_o),
    .scl_oe_o    (scl_oe_o),
    .idle_o      (gen_idle)
  );

  always_comb begin
    rd_val              = '0;
    rd_val[BUSY_BIT]    = busy;
    rd_val[GUARD_BIT]   = 1'b1;
    rd_val[SDA_MON_BIT] = ~sda_oe_o;
    rd_val[RSV_HI_BIT]  = 1'b1;
    rd_val[SCL_MON_BIT] = ~scl_oe_o;
    rd_val[RSV_LO_BIT]  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= RST_VAL;
    else if (rd_en_i) rdata_o <= rd_val;
  end
endmodule

// File: rtl/i2c_cond_ctrl_chk.sv
module i2c_cond_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wdata_i,
  input logic       rd_en_i,
  input logic [7:0] rdata_o,
  input logic       sda_oe_o,
  input logic       scl_oe_o,
  input logic       idle_i
);
  assert_one_line_moves_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!$stable(sda_oe_o) && !$stable(scl_oe_o)));

  assert_const_fields_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rdata_o[6] && rdata_o[4] && rdata_o[2] && rdata_o[1:0] == 2'b00));

  assert_level_monitor_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rdata_o[5] == !$past(sda_oe_o) && rdata_o[3] == !$past(scl_oe_o)));

  assert_guard_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wdata_i[6] && idle_i) |=> idle_i);

  assert_scl_low_after_sda_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> ($past(sda_oe_o) && sda_oe_o));
endmodule

bind i2c_cond_ctrl i2c_cond_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wdata_i  (wdata_i),
  .rd_en_i  (rd_en_i),
  .rdata_o  (rdata_o),
  .sda_oe_o (sda_oe_o),
  .scl_oe_o (scl_oe_o),
  .idle_i   (gen_idle)
);

// File: tb/i2c_cond_ctrl_tb_top.sv
`timescale 1ns/1ps
module i2c_cond_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, half = 8'd2;
  logic [7:0] rdata;
  logic       sda_oe, scl_oe;
  logic       ext_sda_low = 1'b0;
  logic       sda_line, scl_line;
  int         n_chk = 0, n_bad = 0;
  bit         held = 1'b0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = ~(sda_oe | ext_sda_low);
  assign scl_line = ~scl_oe;

  i2c_cond_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .sda_i(sda_line), .scl_i(scl_line),
    .half_div_i(half), .sda_oe_o(sda_oe), .scl_oe_o(scl_oe)
  );

  function automatic logic [7:0] exp_rd(input logic b, input logic sda_l, input logic scl_l);
    return {b, 1'b1, sda_l, 1'b1, scl_l, 1'b1, 2'b00};
  endfunction

  function automatic int h_eff(input logic [7:0] h);
    return (h == 0) ? 1 : int'(h);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_out(input string tag, input logic es, input logic ec);
    chk(tag, {6'b0, sda_oe, scl_oe}, {6'b0, es, ec});
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic rd_chk(input string tag);
    logic [7:0] v;
    tick(4);
    rd(v);
    chk(tag, v, held ? exp_rd(1'b1, 1'b0, 1'b0) : exp_rd(1'b0, 1'b1, 1'b1));
  endtask

  task automatic phase(input string tag, input logic es, input logic ec);
    for (int k = 0; k < h_eff(half); k++) begin
      chk_out(tag, es, ec);
      tick(1);
    end
  endtask

  task automatic do_start();
    wr(8'h80 | (8'($urandom) & 8'h3F));
    phase("R5 start phase", 1'b1, 1'b0);
    chk_out("R5 held", 1'b1, 1'b1);
    held = 1'b1;
    rd_chk("R5 busy after start");
  endtask

  task automatic do_rstart();
    wr(8'h80 | (8'($urandom) & 8'h3F));
    phase("R6 sda release", 1'b0, 1'b1);
    phase("R6 both released", 1'b0, 1'b0);
    phase("R6 sda low", 1'b1, 1'b0);
    chk_out("R6 held", 1'b1, 1'b1);
    rd_chk("R6 busy kept");
  endtask

  task automatic do_stop();
    wr(8'($urandom) & 8'h3F);
    phase("R7 scl released", 1'b1, 1'b0);
    chk_out("R7 released", 1'b0, 1'b0);
    held = 1'b0;
    rd_chk("R7 busy cleared");
  endtask

  task automatic do_guard();
    wr(8'h40 | (8'($urandom) & 8'hBF));
    for (int k = 0; k < 3; k++) begin
      chk_out("R8 guard write", held, held);
      tick(1);
    end
    rd_chk("R8 busy unchanged");
  endtask

  task automatic do_ext();
    logic [7:0] v;
    ext_sda_low = 1'b1;
    tick(4);
    rd(v);
    chk("R3 external start", v, exp_rd(1'b1, 1'b1, 1'b1));
    ext_sda_low = 1'b0;
    tick(4);
    rd(v);
    chk("R4 external stop", v, exp_rd(1'b0, 1'b1, 1'b1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd7321));
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk_out("R1 enables after reset", 1'b0, 1'b0);
    chk("R1 reset rdata", rdata, 8'h7C);
    rd(v);
    chk("R1 first read", v, 8'h7C);
    // R2: rdata holds while rd_en is low
    ext_sda_low = 1'b1; tick(5);
    chk("R2 hold without read", rdata, 8'h7C);
    ext_sda_low = 1'b0; tick(5);

    do_ext();

    // R9: stop while idle is dropped
    wr(8'h00);
    for (int k = 0; k < 3; k++) begin chk_out("R9 idle stop", 1'b0, 1'b0); tick(1); end

    // R11: zero divider acts as one
    half = 8'd0;
    do_start();
    do_rstart();
    do_stop();

    // R9: requests inside a running start phase are dropped
    half = 8'd6;
    wr(8'h80);
    chk_out("R9 phase begun", 1'b1, 1'b0);
    tick(1);
    wr(8'h80);
    wr(8'h00);
    tick(3);
    chk_out("R9 held at phase end", 1'b1, 1'b1);
    tick(14);
    chk_out("R9 still held", 1'b1, 1'b1);
    held = 1'b1;
    half = 8'd3;
    do_stop();

    for (int i = 0; i < 150; i++) begin
      int op;
      half = 8'(1 + $urandom % 6);
      op = $urandom % 4;
      case (op)
        0: if (held) do_rstart(); else do_start();
        1: if (held) do_stop();   else do_start();
        2: do_guard();
        default: if (held) do_guard(); else do_ext();
      endcase
    end
    if (held) do_stop();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule